// File: doc/BRIEF.md
# Image Sensor Frame Timing Generator

This block produces the parallel video stream that a Bayer image sensor presents at its pins: a pixel-clock enable, a frame-valid strobe, a line-valid strobe, a 12-bit pixel bus and a two-bit colour tag that gives the Bayer position of each pixel. A frame has a programmable number of active rows, each with a programmable number of active pixels. Each row is followed by a programmable horizontal gap, and each frame by a programmable number of blank rows. The pixel data come either from a sensor-side input bus or from one of several synthetic test patterns. The stream can therefore be produced and checked with no pixel array present.

Configuration is written through a simple write-only register port. All settings are copied into a working set at the start of each frame, so a write made during a frame never disturbs that frame. A restart command abandons the frame in progress and begins a new one at once with the settings written so far. Two alternative line-valid formats are offered for receivers that expect them: one is combined with frame-valid by XOR, and the other keeps toggling through vertical blanking. Row and column mirroring reverse the order in which array rows and columns are read, while the colour tag keeps its order.

Top module: `sensor_stream_gen`

## Requirements
- R1: Straight after reset the stream is idle (frame_valid, line_valid, pix_data and bayer_phase all 0). It stays idle through the blank rows of the default geometry (2592 x 1944 active, 16 gap pixels, 8 blank rows).
- R2: pix_en is high for one cycle in every PIX_DIV cycles. The stream position moves forward one slot only on a cycle in which pix_en is high.
- R3: A frame has H rows of W+HB slots each, followed by VB blank rows of the same length. frame_valid is high in rows 0..H-1. In the default line-valid format, line_valid is high exactly in slots 0..W-1 of those rows. W is at address 0, H at address 1, HB at address 2 and VB at address 3, each in data bits 11:0.
- R4: With mode bit 0 set (address 4), line_valid equals the default line-valid XOR frame_valid. This setting overrides mode bit 1.
- R5: With mode bit 1 set and bit 0 clear, line_valid is high in slots 0..W-1 of every row, including the blank rows.
- R6: Outside active pixels, pix_data and bayer_phase are 0. For an active pixel, bayer_phase is {output row parity, output column parity}, which gives 0 Gr, 1 R, 2 B, 3 Gb.
- R7: With mode bit 4 set, mode bits 7:5 choose the source. Let ac and ar be the array column and row, A the test value at address 5 and B the test value at address 6. Code 0 gives A on green phases, B on R and ~A on B. Code 1 gives ac. Code 2 gives ar. Code 3 gives ac+ar. Code 4 gives A on even ac and B on odd ac. Code 5 gives 1<<(ac mod 12). Code 6 gives 0xFFF when bit 3 of ar is set and 0 otherwise. Code 7 gives 0. All results are taken modulo 4096.
- R8: With mode bit 4 clear, an active pixel carries sensor_pix.
- R9: With mode bit 2 set, ac = W-1-column, and bayer_phase is unchanged.
- R10: With mode bit 3 set, ar = H-1-row, so rows are emitted from the last row of the window back to the first.
- R11: A value of 0 written to W, H, HB or VB is stored as 1.
- R12: A configuration write takes effect from the next frame start, or from the next restart, and not in the frame that is running.
- R13: A write to address 7 with data bit 0 set makes the next cycle slot 0 of a new frame, with the divider cleared. The first pixel-enable of that frame comes PIX_DIV cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register address |
| cfg_wdata | input | CFG_DW | Register write data |
| sensor_pix | input | 12 | Pixel value from the sensor side, used when no test pattern is selected |
| pix_en | output | 1 | Pixel clock enable; outputs are valid while high |
| frame_valid | output | 1 | High during the active rows of a frame |
| line_valid | output | 1 | Line strobe in the selected format |
| pix_data | output | 12 | Pixel value |
| bayer_phase | output | 2 | Bayer colour of the current active pixel |

## Verification
The outputs are decoded directly from the position and working-set registers, so each pixel's values are already present in the cycle where pix_en is high. The bench samples them on the falling edge of that cycle. A register write is driven at a falling edge and lands at the next rising edge. After a restart write the first sampled slot is the one whose pix_en rises PIX_DIV cycles later, and the bench confirms that spacing at every slot. The bench makes mid-frame writes at a known slot and checks the rest of that frame against the old geometry. It then checks the following frame against the new geometry.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    localparam int DIM_W      = 12;
    localparam int PIX_W      = 12;
    localparam int DEF_WIDTH  = 2592;
    localparam int DEF_HEIGHT = 1944;
    localparam int DEF_HBLANK = 16;
    localparam int DEF_VBLANK = 8;
    localparam int BAR_BIT    = 3;

    localparam logic [3:0] REG_WIDTH   = 4'd0;
    localparam logic [3:0] REG_HEIGHT  = 4'd1;
    localparam logic [3:0] REG_HBLANK  = 4'd2;
    localparam logic [3:0] REG_VBLANK  = 4'd3;
    localparam logic [3:0] REG_MODE    = 4'd4;
    localparam logic [3:0] REG_TVAL_A  = 4'd5;
    localparam logic [3:0] REG_TVAL_B  = 4'd6;
    localparam logic [3:0] REG_RESTART = 4'd7;

    typedef enum logic [2:0] {
        TP_FIELD   = 3'd0,
        TP_HGRAD   = 3'd1,
        TP_VGRAD   = 3'd2,
        TP_DIAG    = 3'd3,
        TP_CLASSIC = 3'd4,
        TP_WALK    = 3'd5,
        TP_BARS    = 3'd6,
        TP_RSVD    = 3'd7
    } tp_sel_e;

    typedef struct packed {
        logic [DIM_W-1:0] width;
        logic [DIM_W-1:0] height;
        logic [DIM_W-1:0] hblank;
        logic [DIM_W-1:0] vblank;
        logic             xor_lv;
        logic             cont_lv;
        logic             mir_col;
        logic             mir_row;
        logic             tp_en;
        tp_sel_e          tp_sel;
        logic [PIX_W-1:0] tv_a;
        logic [PIX_W-1:0] tv_b;
    } cfg_t;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c.width   = DIM_W'(DEF_WIDTH);
        c.height  = DIM_W'(DEF_HEIGHT);
        c.hblank  = DIM_W'(DEF_HBLANK);
        c.vblank  = DIM_W'(DEF_VBLANK);
        c.xor_lv  = 1'b0;
        c.cont_lv = 1'b0;
        c.mir_col = 1'b0;
        c.mir_row = 1'b0;
        c.tp_en   = 1'b0;
        c.tp_sel  = TP_FIELD;
        c.tv_a    = '0;
        c.tv_b    = '0;
        return c;
    endfunction

endpackage

// File: rtl/ssg_regs.sv
module ssg_regs
    import ssg_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output cfg_t          cfg,
    output logic          restart
);

    cfg_t cfg_d, cfg_q;

    function automatic logic [DIM_W-1:0] at_least_one(input logic [DW-1:0] v);
        logic [DIM_W-1:0] t;
        t = v[DIM_W-1:0];
        return (t == '0) ? DIM_W'(1) : t;
    endfunction

    always_comb begin
        cfg_d   = cfg_q;
        restart = 1'b0;
        if (cfg_we) begin
            case (cfg_addr)
                AW'(REG_WIDTH):   cfg_d.width  = at_least_one(cfg_wdata);
                AW'(REG_HEIGHT):  cfg_d.height = at_least_one(cfg_wdata);
                AW'(REG_HBLANK):  cfg_d.hblank = at_least_one(cfg_wdata);
                AW'(REG_VBLANK):  cfg_d.vblank = at_least_one(cfg_wdata);
                AW'(REG_MODE): begin
                    cfg_d.xor_lv  = cfg_wdata[0];
                    cfg_d.cont_lv = cfg_wdata[1];
                    cfg_d.mir_col = cfg_wdata[2];
                    cfg_d.mir_row = cfg_wdata[3];
                    cfg_d.tp_en   = cfg_wdata[4];
                    cfg_d.tp_sel  = tp_sel_e'(cfg_wdata[7:5]);
                end
                AW'(REG_TVAL_A):  cfg_d.tv_a = cfg_wdata[PIX_W-1:0];
                AW'(REG_TVAL_B):  cfg_d.tv_b = cfg_wdata[PIX_W-1:0];
                AW'(REG_RESTART): restart    = cfg_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_default();
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^cfg_wdata[DW-1:DIM_W];

    AST_SIZES_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.width != '0 && cfg_q.height != '0 && cfg_q.hblank != '0 && cfg_q.vblank != '0)); // R11

endmodule

// File: rtl/ssg_timing.sv
module ssg_timing
    import ssg_pkg::*;
#(
    parameter int PIX_DIV = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  cfg_t           cfg_in,
    input  logic           restart,
    output cfg_t           cfg_act,
    output logic [DIM_W:0] row,
    output logic [DIM_W:0] col,
    output logic           pix_en
);

    localparam int DIVW = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
    localparam logic [DIVW-1:0] DIV_LAST = DIVW'(PIX_DIV - 1);

    typedef struct packed {
        logic [DIM_W:0] row;
        logic [DIM_W:0] col;
        logic [DIVW-1:0] div;
        cfg_t           shd;
    } tstate_t;

    tstate_t d, q;
    logic [DIM_W:0] line_len, frame_len;
    logic           slot_en;

    always_comb begin
        line_len  = {1'b0, q.shd.width}  + {1'b0, q.shd.hblank};
        frame_len = {1'b0, q.shd.height} + {1'b0, q.shd.vblank};
        slot_en   = (q.div == DIV_LAST);
        d = q;
        if (restart) begin
            d.row = '0;
            d.col = '0;
            d.div = '0;
            d.shd = cfg_in;
        end else if (slot_en) begin
            d.div = '0;
            if (q.col == line_len - 1'b1) begin
                d.col = '0;
                if (q.row == frame_len - 1'b1) begin
                    d.row = '0;
                    d.shd = cfg_in;
                end else begin
                    d.row = q.row + 1'b1;
                end
            end else begin
                d.col = q.col + 1'b1;
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.row <= (DIM_W+1)'(DEF_HEIGHT);
            q.col <= '0;
            q.div <= '0;
            q.shd <= cfg_default();
        end else begin
            q <= d;
        end
    end

    assign cfg_act = q.shd;
    assign row     = q.row;
    assign col     = q.col;
    assign pix_en  = slot_en;

    AST_RESTART_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (q.row == '0 && q.col == '0 && q.div == '0)); // R13

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.col < line_len && q.row < frame_len)); // R3

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.row == '0 && q.col == '0) |-> $stable(q.shd)); // R12

    generate
        if (PIX_DIV > 1) begin : g_gap
            AST_PIXEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                pix_en |=> !pix_en); // R2
        end
    endgenerate

endmodule

// File: rtl/ssg_pattern.sv
module ssg_pattern
    import ssg_pkg::*;
(
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic             mir_col,
    input  logic             mir_row,
    input  logic             tp_en,
    input  tp_sel_e          tp_sel,
    input  logic [PIX_W-1:0] tv_a,
    input  logic [PIX_W-1:0] tv_b,
    input  logic [DIM_W-1:0] row,
    input  logic [DIM_W-1:0] col,
    input  logic [PIX_W-1:0] sensor_pix,
    output logic [PIX_W-1:0] pix,
    output logic [1:0]       phase
);

    logic [DIM_W-1:0] ac, ar, diag, walk_pos;

    always_comb begin
        ac       = mir_col ? (width  - DIM_W'(1) - col) : col;
        ar       = mir_row ? (height - DIM_W'(1) - row) : row;
        diag     = ac + ar;
        walk_pos = ac % DIM_W'(PIX_W);
        phase    = {row[0], col[0]};
        if (!tp_en) begin
            pix = sensor_pix;
        end else begin
            case (tp_sel)
                TP_FIELD: begin
                    case (phase)
                        2'd1:    pix = tv_b;
                        2'd2:    pix = ~tv_a;
                        default: pix = tv_a;
                    endcase
                end
                TP_HGRAD:   pix = PIX_W'(ac);
                TP_VGRAD:   pix = PIX_W'(ar);
                TP_DIAG:    pix = PIX_W'(diag);
                TP_CLASSIC: pix = ac[0] ? tv_b : tv_a;
                TP_WALK:    pix = PIX_W'(1) << walk_pos;
                TP_BARS:    pix = ar[BAR_BIT] ? '1 : '0;
                default:    pix = '0;
            endcase
        end
    end

endmodule

// File: rtl/sensor_stream_gen.sv
module sensor_stream_gen
    import ssg_pkg::*;
#(
    parameter int PIX_DIV = 2,
    parameter int CFG_AW  = 4,
    parameter int CFG_DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic [PIX_W-1:0]  sensor_pix,
    output logic              pix_en,
    output logic              frame_valid,
    output logic              line_valid,
    output logic [PIX_W-1:0]  pix_data,
    output logic [1:0]        bayer_phase
);

    cfg_t           cfg_reg, cfg_act;
    logic           restart;
    logic [DIM_W:0] row, col;
    logic [PIX_W-1:0] src_pix;
    logic [1:0]     src_phase;
    logic           in_frame, in_cols, active;

    ssg_regs #(.AW(CFG_AW), .DW(CFG_DW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg_reg),
        .restart   (restart)
    );

    ssg_timing #(.PIX_DIV(PIX_DIV)) timing_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_in  (cfg_reg),
        .restart (restart),
        .cfg_act (cfg_act),
        .row     (row),
        .col     (col),
        .pix_en  (pix_en)
    );

    ssg_pattern pattern_i (
        .width      (cfg_act.width),
        .height     (cfg_act.height),
        .mir_col    (cfg_act.mir_col),
        .mir_row    (cfg_act.mir_row),
        .tp_en      (cfg_act.tp_en),
        .tp_sel     (cfg_act.tp_sel),
        .tv_a       (cfg_act.tv_a),
        .tv_b       (cfg_act.tv_b),
        .row        (row[DIM_W-1:0]),
        .col        (col[DIM_W-1:0]),
        .sensor_pix (sensor_pix),
        .pix        (src_pix),
        .phase      (src_phase)
    );

    always_comb begin
        in_frame = (row < {1'b0, cfg_act.height});
        in_cols  = (col < {1'b0, cfg_act.width});
        active   = in_frame && in_cols;
        if (cfg_act.xor_lv)       line_valid = active ^ in_frame;
        else if (cfg_act.cont_lv) line_valid = in_cols;
        else                      line_valid = active;
        frame_valid = in_frame;
        pix_data    = active ? src_pix   : '0;
        bayer_phase = active ? src_phase : 2'd0;
    end

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_act.hblank, cfg_act.vblank};

    AST_LV_WITHIN_FV: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && (cfg_act.xor_lv || !cfg_act.cont_lv)) |-> frame_valid); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> (pix_data == '0 && bayer_phase == 2'd0)); // R6

endmodule

// File: tb/sensor_stream_gen_tb_top.sv
module sensor_stream_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PD         = 2;

    typedef struct {
        int w, h, hb, vb, mode, a, b;
    } bcfg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [11:0] sensor_pix = '0;
    logic        pix_en, frame_valid, line_valid;
    logic [11:0] pix_data;
    logic [1:0]  bayer_phase;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    bcfg_t cur;

    sensor_stream_gen #(.PIX_DIV(PD)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .sensor_pix  (sensor_pix),
        .pix_en      (pix_en),
        .frame_valid (frame_valid),
        .line_valid  (line_valid),
        .pix_data    (pix_data),
        .bayer_phase (bayer_phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int a, input int e);
        total++;
        if (a != e) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, a, e);
        end
    endtask

    function automatic int pattern_val(bcfg_t c, int r, int cl, int sens);
        int sel = (c.mode >> 5) & 7;
        int ac  = ((c.mode >> 2) & 1) ? c.w - 1 - cl : cl;
        int ar  = ((c.mode >> 3) & 1) ? c.h - 1 - r : r;
        int ph  = (r % 2) * 2 + (cl % 2);
        if (((c.mode >> 4) & 1) == 0) return sens;
        case (sel)
            0: return (ph == 1) ? c.b : (ph == 2) ? ((~c.a) & 'hFFF) : c.a;
            1: return ac & 'hFFF;
            2: return ar & 'hFFF;
            3: return (ac + ar) & 'hFFF;
            4: return (ac % 2) ? c.b : c.a;
            5: return (1 << (ac % 12)) & 'hFFF;
            6: return ((ar >> 3) & 1) ? 'hFFF : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_word(bcfg_t c, int k, int sens, output bit act);
        int L   = c.w + c.hb;
        int r   = k / L;
        int cl  = k % L;
        bit fv  = r < c.h;
        bit inc = cl < c.w;
        bit lv;
        int px, ph;
        act = fv && inc;
        if (c.mode & 1)             lv = act ^ fv;
        else if ((c.mode >> 1) & 1) lv = inc;
        else                        lv = act;
        px = act ? pattern_val(c, r, cl, sens) : 0;
        ph = act ? (r % 2) * 2 + (cl % 2) : 0;
        return (int'(fv) << 15) | (int'(lv) << 14) | (ph << 12) | px;
    endfunction

    task automatic next_slot();
        int n = 0;
        @(negedge clk);
        cfg_we = 1'b0;
        n++;
        while (!pix_en) begin
            @(negedge clk);
            cfg_we = 1'b0;
            n++;
            if (n > 8) break;
        end
        chk("R2", "cycles between pixel enables", n, PD);
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(addr);
        cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_restart();
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 4'd7;
        cfg_wdata = 16'd1;
        next_slot();
    endtask

    task automatic load(input bcfg_t c);
        wr(0, c.w); wr(1, c.h); wr(2, c.hb); wr(3, c.vb);
        wr(4, c.mode); wr(5, c.a); wr(6, c.b);
        cur = c;
        do_restart();
    endtask

    task automatic check_frame(input int nslots, input int wr_slot, input int wa,
                               input int wd, input string tag_act);
        bcfg_t c = cur;
        int n = (nslots < 0) ? (c.w + c.hb) * (c.h + c.vb) : nslots;
        for (int k = 0; k < n; k++) begin
            int sens = (k * 37 + 5) & 'hFFF;
            int got, e;
            bit act;
            string tag;
            sensor_pix = 12'(sens);
            #1;
            got = (int'(frame_valid) << 15) | (int'(line_valid) << 14) |
                  (int'(bayer_phase) << 12) | int'(pix_data);
            e = exp_word(c, k, sens, act);
            tag = (act || tag_act == "R4" || tag_act == "R5") ? tag_act : "R6";
            chk(tag, $sformatf("slot %0d {fv,lv,phase,pix}", k), got, e);
            if (k == wr_slot) begin
                cfg_we    = 1'b1;
                cfg_addr  = 4'(wa);
                cfg_wdata = 16'(wd);
            end
            next_slot();
        end
    endtask

    initial begin
        bcfg_t base, c;
        base = '{w: 14, h: 10, hb: 2, vb: 1, mode: 0, a: 'hA5C, b: 'h3F1};
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R1", "idle outputs after reset",
                (int'(frame_valid) << 15) | (int'(line_valid) << 14) |
                (int'(bayer_phase) << 12) | int'(pix_data), 0);
        end

        // R8 pass-through, then R3 geometry across a natural frame wrap
        load(base);
        check_frame(-1, -1, 0, 0, "R8");
        check_frame(-1, -1, 0, 0, "R3");

        // R7 / R9 / R10 pattern and mirror sweep
        for (int sel = 0; sel < 8; sel++) begin
            for (int m = 0; m < 4; m++) begin
                c = base;
                c.mode = 16 | (sel << 5) | (m << 2);
                load(c);
                check_frame(-1, -1, 0, 0, (m & 1) ? "R9" : (m & 2) ? "R10" : "R7");
            end
        end

        // R4 XOR format, alone and over continuous
        c = base; c.mode = 1 | 16 | (1 << 5);
        load(c);
        check_frame(-1, -1, 0, 0, "R4");
        c.mode = 3 | 16 | (3 << 5);
        load(c);
        check_frame(-1, -1, 0, 0, "R4");

        // R5 continuous format with several blank rows
        c = base; c.mode = 2 | 16 | (4 << 5); c.vb = 3;
        load(c);
        check_frame(-1, -1, 0, 0, "R5");

        // R11 zero blanking stored as one
        c = base; c.mode = 16 | (3 << 5); c.hb = 0; c.vb = 0;
        wr(0, c.w); wr(1, c.h); wr(2, 0); wr(3, 0);
        wr(4, c.mode); wr(5, c.a); wr(6, c.b);
        c.hb = 1; c.vb = 1;
        cur = c;
        do_restart();
        check_frame(-1, -1, 0, 0, "R11");

        // R12 mid-frame width change waits for the next frame
        c = base; c.mode = 16 | (1 << 5);
        load(c);
        check_frame(-1, 30, 0, 6, "R12");
        cur.w = 6;
        check_frame(-1, -1, 0, 0, "R12");

        // R13 restart aborts the frame at once
        check_frame(41, 40, 7, 1, "R13");
        check_frame(-1, -1, 0, 0, "R13");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule